// File: doc/BRIEF.md
# Lockable Instruction Cache Controller

This block sits between an instruction fetch unit and the next level of memory. It keeps a direct-mapped store of instruction lines and serves fetch requests that hit in it. On a miss it goes to memory. It can either fill the whole line with a wrapping burst or make one single-word read that does not change the store.

Three controls steer the block. The enable control switches caching on and off. The lock control freezes the current contents: hits are still served, but misses bypass the store. A flash-invalidate pulse clears every line, and it works whether or not caching is enabled. New enable and lock values are held back until no fetch is in flight. Each access carries a caching-inhibited attribute. That attribute is passed to memory unchanged in every mode, and an inhibited access always bypasses the store.

Top module: `lockable_icache`

## Requirements
- R1: After reset, caching is disabled, the lock is off, no line is valid, and neither `cpu_rsp_valid` nor `mem_req_valid` is asserted.
- R2: While enabled, a non-inhibited fetch that hits returns its stored word with `cpu_rsp_valid` one cycle after acceptance, and no memory request is made.
- R3: While enabled and unlocked, a non-inhibited miss issues one request with `mem_req_burst`=1 at the requested word address. The memory returns 4 beats of the line, starting at word offset `addr[3:2]` and wrapping modulo 4. The requested word is returned one cycle after the first beat, and the line (tag `addr[31:8]`, index `addr[7:4]`) becomes valid after the last beat. Any line previously held at that index is replaced.
- R4: While locked, hits are still served from the store. A miss issues a single-beat read (`mem_req_burst`=0) and changes no valid bit or tag, so the same address misses again.
- R5: A fetch with `cpu_req_inhibit`=1 always performs a single-beat read, even if its line is cached and the cache is unlocked. It never allocates a line and never invalidates one.
- R6: For every memory request, `mem_req_inhibit` equals the `cpu_req_inhibit` value of the fetch that caused it, whatever the lock and enable state.
- R7: While disabled, every fetch performs a single-beat read and valid bits are untouched. Lines filled before disabling hit again after re-enabling, unless a flash invalidate was done in between.
- R8: A pulse on `inv_all` clears every valid bit, whether caching is enabled or disabled. The clear takes effect at the first idle cycle.
- R9: New `cfg_enable`/`cfg_lock` values are copied to `en_active`/`lock_active` only on a clock edge where no fetch is in flight. While a change or an invalidate is pending, `cpu_req_ready` is low.
- R10: At most one miss is outstanding. After a fetch is accepted, either its response arrives on the next cycle (hit) or `cpu_req_ready` stays low until the miss is answered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_enable | input | 1 | Requested cache enable |
| cfg_lock | input | 1 | Requested content lock |
| inv_all | input | 1 | Flash-invalidate pulse |
| en_active | output | 1 | Enable value currently applied |
| lock_active | output | 1 | Lock value currently applied |
| cpu_req_valid | input | 1 | Fetch request valid |
| cpu_req_ready | output | 1 | Fetch request can be accepted |
| cpu_req_addr | input | AW | Fetch byte address |
| cpu_req_inhibit | input | 1 | Caching-inhibited attribute of the fetch |
| cpu_rsp_valid | output | 1 | Fetched word valid (one cycle) |
| cpu_rsp_data | output | DW | Fetched instruction word |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | AW | Address of the first word to read |
| mem_req_burst | output | 1 | 1: wrapping line burst, 0: single beat |
| mem_req_inhibit | output | 1 | Caching-inhibited attribute passed to memory |
| mem_rsp_valid | input | 1 | Read data beat valid |
| mem_rsp_data | input | DW | Read data beat |

## Verification
The bench aims at the points where the lock, inhibit and enable paths split. A design that allocated on locked or inhibited misses would turn the repeated miss into a hit with no memory request. A design that cleared valid bits on disable would turn the post-re-enable hit into a burst. The wrap order of a fill is checked by fetching the other words of the line after a mid-line critical word: storing beats at linear offsets returns the wrong words. The lock is flipped while a miss is in flight, and the applied state is sampled every cycle of that miss, so applying the change early is caught. A flash invalidate issued while disabled must force a burst after re-enable.

// File: rtl/ifc_pkg.sv
package ifc_pkg;

  typedef int unsigned uint_t;

  typedef enum logic [1:0] {
    FS_IDLE = 2'd0,
    FS_REQ  = 2'd1,
    FS_WAIT = 2'd2
  } fill_state_t;

  // Word offset of beat number 'step' of a fill that starts at 'first'.
  function automatic uint_t wrap_add(uint_t first, uint_t step, uint_t words);
    return (first + step) % words;
  endfunction

endpackage

// File: rtl/ifc_ctrl.sv
module ifc_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_enable,
  input  logic cfg_lock,
  input  logic inv_all,
  input  logic idle,
  output logic en_q,
  output logic lock_q,
  output logic hold,
  output logic inv_apply
);

  logic inv_pend_q;
  logic cfg_diff;

  assign cfg_diff  = (cfg_enable != en_q) || (cfg_lock != lock_q);
  assign hold      = cfg_diff || inv_pend_q;
  assign inv_apply = idle && inv_pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q       <= 1'b0;
      lock_q     <= 1'b0;
      inv_pend_q <= 1'b0;
    end else begin
      if (idle && cfg_diff) begin
        en_q   <= cfg_enable;
        lock_q <= cfg_lock;
      end
      inv_pend_q <= inv_all || (inv_pend_q && !inv_apply);
    end
  end

  // R9: controls never move while a fetch is outstanding
  a_r9_hold_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !idle |=> ($stable(en_q) && $stable(lock_q)));

endmodule

// File: rtl/ifc_store.sv
module ifc_store #(
  parameter int SETS       = 16,
  parameter int LINE_WORDS = 4,
  parameter int TAG_W      = 24,
  parameter int DW         = 32,
  localparam int IDX_W     = $clog2(SETS),
  localparam int OFF_W     = $clog2(LINE_WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic [OFF_W-1:0] rd_off,
  input  logic [TAG_W-1:0] rd_tag,
  output logic             hit,
  output logic [DW-1:0]    rd_data,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [OFF_W-1:0] wr_off,
  input  logic [DW-1:0]    wr_data,
  input  logic             set_en,
  input  logic [TAG_W-1:0] set_tag,
  input  logic             clr_all
);

  logic             valid_q [SETS];
  logic [SETS-1:0]  valid_vec;
  logic [TAG_W-1:0] tag_q   [SETS];
  logic [DW-1:0]    data_q  [SETS][LINE_WORDS];

  for (genvar s = 0; s < SETS; s++) begin : g_set
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  valid_q[s] <= 1'b0;
      else if (clr_all)                            valid_q[s] <= 1'b0;
      else if (set_en && wr_idx == IDX_W'(s))      valid_q[s] <= 1'b1;
    end
    assign valid_vec[s] = valid_q[s];
  end

  always_ff @(posedge clk) begin
    if (set_en) tag_q[wr_idx] <= set_tag;
    if (wr_en)  data_q[wr_idx][wr_off] <= wr_data;
  end

  assign hit     = valid_q[rd_idx] && (tag_q[rd_idx] == rd_tag);
  assign rd_data = data_q[rd_idx][rd_off];

  // R8: a flash clear leaves no valid line behind
  a_r8_flash_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all |=> (valid_vec == '0));

endmodule

// File: rtl/ifc_miss.sv
module ifc_miss
  import ifc_pkg::*;
#(
  parameter int AW         = 32,
  parameter int DW         = 32,
  parameter int SETS       = 16,
  parameter int LINE_WORDS = 4,
  localparam int IDX_W     = $clog2(SETS),
  localparam int OFF_W     = $clog2(LINE_WORDS),
  localparam int TAG_W     = AW - IDX_W - OFF_W - 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc,
  input  logic [AW-1:0]    req_addr,
  input  logic             req_inh,
  input  logic             hit,
  input  logic [DW-1:0]    hit_data,
  input  logic             en_q,
  input  logic             lock_q,
  output logic             idle,
  output logic             cpu_rsp_valid,
  output logic [DW-1:0]    cpu_rsp_data,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic [AW-1:0]    mem_req_addr,
  output logic             mem_req_burst,
  output logic             mem_req_inhibit,
  input  logic             mem_rsp_valid,
  input  logic [DW-1:0]    mem_rsp_data,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic [OFF_W-1:0] wr_off,
  output logic [DW-1:0]    wr_data,
  output logic             set_en,
  output logic [TAG_W-1:0] set_tag
);

  localparam logic [OFF_W-1:0] LAST_BEAT = OFF_W'(LINE_WORDS - 1);

  function automatic logic [OFF_W-1:0] off_of(logic [AW-1:0] a);
    return a[2 +: OFF_W];
  endfunction
  function automatic logic [IDX_W-1:0] idx_of(logic [AW-1:0] a);
    return a[2 + OFF_W +: IDX_W];
  endfunction
  function automatic logic [TAG_W-1:0] tag_of(logic [AW-1:0] a);
    return a[AW-1 -: TAG_W];
  endfunction

  fill_state_t      st_q;
  logic [AW-1:0]    a_q;
  logic             inh_q;
  logic             burst_q;
  logic [OFF_W-1:0] cnt_q;
  logic             serve_hit;
  logic             alloc;
  logic             beat;

  assign serve_hit = acc && en_q && !req_inh && hit;
  assign alloc     = en_q && !lock_q && !req_inh;
  assign beat      = (st_q == FS_WAIT) && mem_rsp_valid;
  assign idle      = (st_q == FS_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q          <= FS_IDLE;
      a_q           <= '0;
      inh_q         <= 1'b0;
      burst_q       <= 1'b0;
      cnt_q         <= '0;
      cpu_rsp_valid <= 1'b0;
      cpu_rsp_data  <= '0;
    end else begin
      cpu_rsp_valid <= 1'b0;
      unique case (st_q)
        FS_IDLE: begin
          if (serve_hit) begin
            cpu_rsp_valid <= 1'b1;
            cpu_rsp_data  <= hit_data;
          end else if (acc) begin
            st_q    <= FS_REQ;
            a_q     <= req_addr;
            inh_q   <= req_inh;
            burst_q <= alloc;
            cnt_q   <= '0;
          end
        end
        FS_REQ: if (mem_req_ready) st_q <= FS_WAIT;
        FS_WAIT: begin
          if (mem_rsp_valid) begin
            cnt_q <= cnt_q + OFF_W'(1);
            if (cnt_q == '0) begin
              cpu_rsp_valid <= 1'b1;
              cpu_rsp_data  <= mem_rsp_data;
            end
            if (!burst_q || cnt_q == LAST_BEAT) st_q <= FS_IDLE;
          end
        end
        default: st_q <= FS_IDLE;
      endcase
    end
  end

  assign mem_req_valid   = (st_q == FS_REQ);
  assign mem_req_addr    = a_q;
  assign mem_req_burst   = burst_q;
  assign mem_req_inhibit = inh_q;

  assign wr_en   = beat && burst_q;
  assign wr_idx  = idx_of(a_q);
  assign wr_off  = OFF_W'(wrap_add(uint_t'(off_of(a_q)), uint_t'(cnt_q), uint_t'(LINE_WORDS)));
  assign wr_data = mem_rsp_data;
  assign set_en  = wr_en && (cnt_q == LAST_BEAT);
  assign set_tag = tag_of(a_q);

  // R4: a locked cache never allocates
  a_r4_no_alloc_locked: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |-> !lock_q);

  // R5, R7: bursts only for enabled, unlocked, cacheable accesses
  a_r5_burst_only_cacheable: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_burst) |-> (!mem_req_inhibit && en_q && !lock_q));

  // R2: a hit in the store answers on the next cycle with the stored word
  a_r2_hit_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && hit && en_q && !req_inh) |=> (cpu_rsp_valid && cpu_rsp_data == $past(hit_data)));

endmodule

// File: rtl/lockable_icache.sv
module lockable_icache
  import ifc_pkg::*;
#(
  parameter int AW         = 32,
  parameter int DW         = 32,
  parameter int SETS       = 16,
  parameter int LINE_WORDS = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_enable,
  input  logic          cfg_lock,
  input  logic          inv_all,
  output logic          en_active,
  output logic          lock_active,
  input  logic          cpu_req_valid,
  output logic          cpu_req_ready,
  input  logic [AW-1:0] cpu_req_addr,
  input  logic          cpu_req_inhibit,
  output logic          cpu_rsp_valid,
  output logic [DW-1:0] cpu_rsp_data,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic [AW-1:0] mem_req_addr,
  output logic          mem_req_burst,
  output logic          mem_req_inhibit,
  input  logic          mem_rsp_valid,
  input  logic [DW-1:0] mem_rsp_data
);

  localparam int OFF_W = $clog2(LINE_WORDS);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = AW - IDX_W - OFF_W - 2;

  logic             idle, hold, inv_apply, acc;
  logic             hit;
  logic [DW-1:0]    hit_data;
  logic             wr_en, set_en;
  logic [IDX_W-1:0] wr_idx;
  logic [OFF_W-1:0] wr_off;
  logic [DW-1:0]    wr_data;
  logic [TAG_W-1:0] set_tag;

  assign cpu_req_ready = idle && !hold;
  assign acc           = cpu_req_valid && cpu_req_ready;

  ifc_ctrl u_ctrl (
    .clk, .rst_n, .cfg_enable, .cfg_lock, .inv_all, .idle,
    .en_q(en_active), .lock_q(lock_active), .hold, .inv_apply
  );

  ifc_store #(.SETS(SETS), .LINE_WORDS(LINE_WORDS), .TAG_W(TAG_W), .DW(DW)) u_store (
    .clk, .rst_n,
    .rd_idx (cpu_req_addr[2 + OFF_W +: IDX_W]),
    .rd_off (cpu_req_addr[2 +: OFF_W]),
    .rd_tag (cpu_req_addr[AW-1 -: TAG_W]),
    .hit, .rd_data(hit_data),
    .wr_en, .wr_idx, .wr_off, .wr_data, .set_en, .set_tag,
    .clr_all(inv_apply)
  );

  ifc_miss #(.AW(AW), .DW(DW), .SETS(SETS), .LINE_WORDS(LINE_WORDS)) u_miss (
    .clk, .rst_n, .acc,
    .req_addr(cpu_req_addr), .req_inh(cpu_req_inhibit),
    .hit, .hit_data, .en_q(en_active), .lock_q(lock_active),
    .idle, .cpu_rsp_valid, .cpu_rsp_data,
    .mem_req_valid, .mem_req_ready, .mem_req_addr, .mem_req_burst, .mem_req_inhibit,
    .mem_rsp_valid, .mem_rsp_data,
    .wr_en, .wr_idx, .wr_off, .wr_data, .set_en, .set_tag
  );

  // R6: the request to memory carries the fetch's own inhibit attribute and address
  a_r6_inhibit_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req_valid) |-> (mem_req_inhibit == $past(cpu_req_inhibit) &&
                              mem_req_addr == $past(cpu_req_addr)));

  // R10: after acceptance either the hit answers or no second fetch is taken
  a_r10_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req_valid && cpu_req_ready) |=> (cpu_rsp_valid || !cpu_req_ready));

endmodule

// File: tb/test_lockable_icache.sv
`timescale 1ns/1ps
module test_lockable_icache;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_enable, cfg_lock, inv_all;
  logic        en_active, lock_active;
  logic        cpu_req_valid, cpu_req_ready, cpu_req_inhibit;
  logic [31:0] cpu_req_addr;
  logic        cpu_rsp_valid;
  logic [31:0] cpu_rsp_data;
  logic        mem_req_valid, mem_req_ready, mem_req_burst, mem_req_inhibit;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid;
  logic [31:0] mem_rsp_data;

  always #2.5 clk = ~clk;

  lockable_icache i_lockable_icache (.*);

  int tests = 0;
  int fails = 0;

  // reference model state
  bit          mv [16];
  logic [23:0] mt [16];
  bit          en_m, lock_m;

  // memory side observation
  int          mreq_cnt = 0;
  bit          mem_busy = 0;
  logic [31:0] seen_addr;
  logic        seen_burst, seen_inh;

  function automatic logic [31:0] memfn(logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h0BAD_F00D;
  endfunction

  task automatic chk(bit ok, string r, string what, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", r, what, act, exp);
    end
  endtask

  // 0 = hit, 1 = line burst, 2 = single beat
  function automatic int predict(logic [31:0] a, logic inh);
    if (!en_m || inh) return 2;
    if (mv[a[7:4]] && mt[a[7:4]] == a[31:8]) return 0;
    if (lock_m) return 2;
    return 1;
  endfunction

  // behavioural next-level memory
  initial begin
    mem_req_ready = 1'b0;
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = '0;
    forever begin
      @(negedge clk);
      if (mem_req_valid) begin
        mem_busy   = 1;
        mreq_cnt++;
        seen_addr  = mem_req_addr;
        seen_burst = mem_req_burst;
        seen_inh   = mem_req_inhibit;
        mem_req_ready = 1'b1;
        @(negedge clk);
        mem_req_ready = 1'b0;
        repeat (2) @(negedge clk);
        for (int i = 0; i < (seen_burst ? 4 : 1); i++) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = memfn({seen_addr[31:4], 2'(seen_addr[3:2] + 2'(i)), 2'b00});
          @(negedge clk);
        end
        mem_rsp_valid = 1'b0;
        mem_busy = 0;
      end
    end
  end

  // per-cycle check: nothing accepted while a memory request is open (R10)
  always @(negedge clk) begin
    if (rst_n && mem_req_valid) chk(!cpu_req_ready, "R10", "ready during miss", 32'(cpu_req_ready), 0);
  end

  task automatic fetch(logic [31:0] a, logic inh, bit flip, string r);
    int kind, cyc, c0;
    kind = predict(a, inh);
    @(negedge clk);
    cpu_req_valid = 1'b1; cpu_req_addr = a; cpu_req_inhibit = inh;
    while (!cpu_req_ready) @(negedge clk);
    c0 = mreq_cnt;
    @(negedge clk);
    cpu_req_valid = 1'b0;
    if (flip) cfg_lock = ~cfg_lock;
    cyc = 1;
    while (!cpu_rsp_valid && cyc < 60) begin
      if (flip) chk(lock_active == lock_m, "R9", "lock applied mid-fetch", 32'(lock_active), 32'(lock_m));
      @(negedge clk); cyc++;
    end
    chk(cpu_rsp_valid, r, "response arrived", 32'(cpu_rsp_valid), 1);
    chk(cpu_rsp_data == memfn(a), r, "fetched word", cpu_rsp_data, memfn(a));
    if (kind == 0) begin
      chk(cyc == 1, r, "hit latency", cyc, 1);
      chk(mreq_cnt == c0, r, "hit made memory request", mreq_cnt - c0, 0);
    end else begin
      chk(mreq_cnt == c0 + 1, r, "memory request count", mreq_cnt - c0, 1);
      chk(seen_burst == (kind == 1), r, "burst flag", 32'(seen_burst), 32'(kind == 1));
      chk(seen_inh == inh, "R6", "inhibit passthrough", 32'(seen_inh), 32'(inh));
      chk(seen_addr == a, r, "request address", seen_addr, a);
      if (kind == 1) begin mv[a[7:4]] = 1; mt[a[7:4]] = a[31:8]; end
    end
    if (flip) begin
      chk(lock_active == lock_m, "R9", "lock at response", 32'(lock_active), 32'(lock_m));
      @(negedge clk);
      chk(lock_active == cfg_lock, "R9", "lock after idle", 32'(lock_active), 32'(cfg_lock));
      lock_m = cfg_lock;
    end
    while (mem_busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic set_cfg(bit e, bit l);
    @(negedge clk);
    cfg_enable = e; cfg_lock = l;
    #0.1;
    if (e != en_m || l != lock_m) chk(!cpu_req_ready, "R9", "ready while change pending", 32'(cpu_req_ready), 0);
    @(negedge clk);
    chk(en_active == e, "R9", "enable applied", 32'(en_active), 32'(e));
    chk(lock_active == l, "R9", "lock applied", 32'(lock_active), 32'(l));
    en_m = e; lock_m = l;
  endtask

  task automatic flash();
    @(negedge clk); inv_all = 1'b1;
    @(negedge clk); inv_all = 1'b0;
    chk(!cpu_req_ready, "R8", "ready while invalidate pending", 32'(cpu_req_ready), 0);
    @(negedge clk);
    for (int i = 0; i < 16; i++) mv[i] = 0;
  endtask

  initial begin
    cfg_enable = 0; cfg_lock = 0; inv_all = 0;
    cpu_req_valid = 0; cpu_req_addr = '0; cpu_req_inhibit = 0;
    en_m = 0; lock_m = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(en_active == 0,     "R1", "enable after reset", 32'(en_active), 0);
    chk(lock_active == 0,   "R1", "lock after reset", 32'(lock_active), 0);
    chk(cpu_rsp_valid == 0, "R1", "rsp after reset", 32'(cpu_rsp_valid), 0);
    chk(mem_req_valid == 0, "R1", "mem req after reset", 32'(mem_req_valid), 0);
    chk(cpu_req_ready == 1, "R1", "ready after reset", 32'(cpu_req_ready), 1);

    fetch(32'h1000_0108, 0, 0, "R7");      // disabled: single
    fetch(32'h1000_0108, 0, 0, "R7");      // still no allocation
    set_cfg(1, 0);
    fetch(32'h1000_0108, 0, 0, "R3");      // burst, critical word at offset 2
    fetch(32'h1000_010C, 0, 0, "R3");      // wrapped beats landed correctly
    fetch(32'h1000_0100, 0, 0, "R3");
    fetch(32'h1000_0104, 0, 0, "R2");
    fetch(32'h2000_0104, 0, 0, "R3");      // same index, new tag: replace
    fetch(32'h1000_0108, 0, 0, "R3");      // evicted, burst again
    fetch(32'h3000_0230, 0, 0, "R3");

    fetch(32'h1000_0108, 1, 0, "R5");      // inhibited though cached
    fetch(32'h1000_0108, 0, 0, "R5");      // line untouched: hit
    fetch(32'h4000_0340, 1, 0, "R5");
    fetch(32'h4000_0340, 0, 0, "R5");      // no allocation: burst now

    set_cfg(1, 1);
    fetch(32'h3000_0234, 0, 0, "R4");      // locked hit
    fetch(32'h5000_0450, 0, 0, "R4");      // locked miss: single
    fetch(32'h5000_0450, 0, 0, "R4");      // still not allocated
    fetch(32'h3000_0230, 1, 0, "R6");      // locked, inhibited
    fetch(32'h6000_0560, 0, 1, "R9");      // unlock requested mid-miss
    fetch(32'h6000_0560, 0, 0, "R9");      // now unlocked: burst

    set_cfg(0, 0);
    fetch(32'h3000_0230, 0, 0, "R7");      // disabled: single
    set_cfg(1, 0);
    fetch(32'h3000_0230, 0, 0, "R7");      // line kept over disable: hit

    set_cfg(0, 0);
    flash();                               // invalidate while disabled
    set_cfg(1, 0);
    fetch(32'h3000_0230, 0, 0, "R8");
    fetch(32'h1000_0108, 0, 0, "R8");
    flash();                               // invalidate while enabled
    fetch(32'h3000_0230, 0, 0, "R8");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(200000 * 5.0);
    fails++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule